// File: doc/BRIEF.md
# Conditional Microoperation Unit

This block holds a small file of equal-width registers. In each clock cycle it can carry out one register-transfer microoperation. The operation reads two source registers, chosen by index, and writes its result to a destination register, also chosen by index. The available operations are:

- an external load
- add, and subtract through the same adder
- increment and decrement
- ones and twos complement
- bitwise OR, AND and XOR
- one-place shifts left and right that fill the vacated bit with zero

A write happens only when the control condition is true. That condition is the OR of two control terms. A registered carry flag records the carry out of each arithmetic write.

A sequencer drives the operation fields and the two control terms. The whole register file comes out on one flat output bus, so it can be observed and checked.

Top module: `uop_unit`

## Requirements
- R1: When k1 and k2 are both 0, no register and no carry flag changes at the next rising edge, whatever the other inputs are.
- R2: The operation takes effect at the next rising clock edge when k1 OR k2 is 1. Either term on its own is enough.
- R3: Opcode 1 with sub_mode=0 writes (A + B) mod 2^W to the destination and sets carry to the carry-out. With sub_mode=1 it writes A + (NOT B) + 1 and sets carry to 1 exactly when A >= B.
- R4: Opcode 2 writes A + 1, and carry is the carry-out. Opcode 3 writes A - 1 (computed as A plus all ones), and carry is 1 unless A was 0.
- R5: Opcode 4 writes NOT A and leaves carry unchanged. Opcode 5 writes (NOT A) + 1, and carry is 1 only when A was 0.
- R6: Opcodes 6, 7 and 8 write A OR B, A AND B and A XOR B, and leave carry unchanged.
- R7: Opcode 9 shifts A left by one and writes 0 into bit 0. Opcode 10 shifts A right by one and writes 0 into the top bit. Carry is unchanged. For example, 11001001 becomes 10010010 after a left shift and 01100100 after a right shift.
- R8: Opcode 0 writes load_data into the destination and leaves carry unchanged.
- R9: Opcodes 11 to 15 change no register and do not change the carry flag.
- R10: Only the destination register can change. Any index may serve as A, B or destination, and they may coincide. Sources are read as they were before the edge.
- R11: After reset every register and the carry flag are 0. Register i appears on reg_flat[i*W +: W].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| k1 | input | 1 | Control term 1 |
| k2 | input | 1 | Control term 2 |
| sub_mode | input | 1 | Selects subtract for opcode 1 |
| op | input | 4 | Operation code |
| src_a | input | log2(NREGS) | Index of source A |
| src_b | input | log2(NREGS) | Index of source B |
| dst | input | log2(NREGS) | Index of destination |
| load_data | input | WIDTH | Data for opcode 0 |
| reg_flat | output | NREGS*WIDTH | All register contents |
| carry | output | 1 | Registered carry flag |

## Verification
On every cycle, the checker confirms four things. An idle cycle with both control terms low freezes the register file and the carry flag. Registers other than the destination stay stable. Unknown opcodes change nothing. Logic and shift operations leave the carry flag alone. It also checks each add against the previous source values, the zero fill bit of each shift, and each load.

The remaining arithmetic values need a scoreboard model fed by the bench. These include subtract, the borrow sense of carry, the carry behaviour of decrement and twos complement, and reading a source that is also the destination. The bench also shows that each control term alone can trigger a write.

// File: rtl/uop_unit.sv
module uop_unit #(
  parameter int WIDTH = 8,
  parameter int NREGS = 4,
  localparam int AW = $clog2(NREGS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   k1,
  input  logic                   k2,
  input  logic                   sub_mode,
  input  logic [3:0]             op,
  input  logic [AW-1:0]          src_a,
  input  logic [AW-1:0]          src_b,
  input  logic [AW-1:0]          dst,
  input  logic [WIDTH-1:0]       load_data,
  output logic [NREGS*WIDTH-1:0] reg_flat,
  output logic                   carry
);
  localparam logic [3:0] OP_LOAD = 4'd0, OP_ADD = 4'd1, OP_INC = 4'd2, OP_DEC = 4'd3,
                         OP_NOT = 4'd4, OP_NEG = 4'd5, OP_OR = 4'd6, OP_AND = 4'd7,
                         OP_XOR = 4'd8, OP_SHL = 4'd9, OP_SHR = 4'd10;

  logic [WIDTH-1:0] rf [NREGS];
  logic [WIDTH-1:0] a, b;
  logic [WIDTH:0]   res;
  logic             wr, arith;
  logic             go;

  assign a  = rf[src_a];
  assign b  = rf[src_b];
  assign go = (k1 | k2) & wr;

  for (genvar i = 0; i < NREGS; i++) begin : g_out
    assign reg_flat[i*WIDTH +: WIDTH] = rf[i];
  end

  always_comb begin
    res   = '0;
    wr    = 1'b1;
    arith = 1'b0;
    case (op)
      OP_LOAD: res = {1'b0, load_data};
      OP_ADD: begin
        arith = 1'b1;
        res   = sub_mode ? {1'b0, a} + {1'b0, ~b} + (WIDTH+1)'(1)
                         : {1'b0, a} + {1'b0, b};
      end
      OP_INC: begin arith = 1'b1; res = {1'b0, a} + (WIDTH+1)'(1); end
      OP_DEC: begin arith = 1'b1; res = {1'b0, a} + {1'b0, {WIDTH{1'b1}}}; end
      OP_NOT: res = {1'b0, ~a};
      OP_NEG: begin arith = 1'b1; res = {1'b0, ~a} + (WIDTH+1)'(1); end
      OP_OR:  res = {1'b0, a | b};
      OP_AND: res = {1'b0, a & b};
      OP_XOR: res = {1'b0, a ^ b};
      OP_SHL: res = {1'b0, a[WIDTH-2:0], 1'b0};
      OP_SHR: res = {2'b00, a[WIDTH-1:1]};
      default: wr = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
      carry <= 1'b0;
    end else if (go) begin
      rf[dst] <= res[WIDTH-1:0];
      if (arith) carry <= res[WIDTH];
    end
  end
endmodule

module uop_unit_chk #(
  parameter int WIDTH = 8,
  parameter int NREGS = 4,
  localparam int AW = $clog2(NREGS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   k1,
  input logic                   k2,
  input logic                   sub_mode,
  input logic [3:0]             op,
  input logic [AW-1:0]          src_a,
  input logic [AW-1:0]          src_b,
  input logic [AW-1:0]          dst,
  input logic [WIDTH-1:0]       load_data,
  input logic [NREGS*WIDTH-1:0] reg_flat,
  input logic                   carry
);
  function automatic logic [WIDTH-1:0] rd(logic [NREGS*WIDTH-1:0] f, logic [AW-1:0] i);
    return f[i*WIDTH +: WIDTH];
  endfunction

  logic en;
  assign en = k1 | k2;

  assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(reg_flat) && $stable(carry));

  assert_bad_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op > 4'd10) |=> $stable(reg_flat) && $stable(carry));

  assert_logic_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd0 || op == 4'd4 || (op >= 4'd6 && op <= 4'd10)) |=> $stable(carry));

  assert_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 4'd1 && !sub_mode) |=>
      {carry, rd(reg_flat, $past(dst))} ==
      {1'b0, rd($past(reg_flat), $past(src_a))} + {1'b0, rd($past(reg_flat), $past(src_b))});

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 4'd0) |=> rd(reg_flat, $past(dst)) == $past(load_data));

  assert_shl_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 4'd9) |=> rd(reg_flat, $past(dst))[0] == 1'b0);

  assert_shr_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 4'd10) |=> rd(reg_flat, $past(dst))[WIDTH-1] == 1'b0);

  for (genvar i = 0; i < NREGS; i++) begin : g_keep
    assert_other_regs_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dst != AW'(i)) |=> $stable(reg_flat[i*WIDTH +: WIDTH]));
  end
endmodule

bind uop_unit uop_unit_chk #(.WIDTH(WIDTH), .NREGS(NREGS)) chk (
  .clk(clk), .rst_n(rst_n), .k1(k1), .k2(k2), .sub_mode(sub_mode), .op(op),
  .src_a(src_a), .src_b(src_b), .dst(dst), .load_data(load_data),
  .reg_flat(reg_flat), .carry(carry));

// File: tb/uop_unit_test.sv
`timescale 1ns/1ps
module uop_unit_test;
  localparam int W = 8;
  localparam int N = 4;
  localparam int AW = $clog2(N);

  logic clk = 0, rst_n = 0, k1 = 0, k2 = 0, sub_mode = 0;
  logic [3:0] op = 4'd15;
  logic [AW-1:0] src_a = '0, src_b = '0, dst = '0;
  logic [W-1:0] load_data = '0;
  logic [N*W-1:0] reg_flat;
  logic carry;

  always #2 clk = ~clk;

  uop_unit #(.WIDTH(W), .NREGS(N)) uut (
    .clk(clk), .rst_n(rst_n), .k1(k1), .k2(k2), .sub_mode(sub_mode), .op(op),
    .src_a(src_a), .src_b(src_b), .dst(dst), .load_data(load_data),
    .reg_flat(reg_flat), .carry(carry));

  typedef struct {
    logic [N*W-1:0] regs;
    logic           c;
    string          tag;
  } item_t;

  item_t q[$];
  logic [W-1:0] m [N];
  logic mc;
  int checks = 0, errors = 0;

  function automatic logic [N*W-1:0] flat();
    logic [N*W-1:0] f;
    for (int i = 0; i < N; i++) f[i*W +: W] = m[i];
    return f;
  endfunction

  task automatic do_op(input bit t1, input bit t2, input bit x, input logic [3:0] o,
                       input int ia, input int ib, input int id,
                       input logic [W-1:0] dv, input string tag);
    logic [W:0] r;
    logic [W-1:0] va, vb;
    bit wr, ar;
    item_t it;
    @(negedge clk);
    k1 = t1; k2 = t2; sub_mode = x; op = o;
    src_a = AW'(ia); src_b = AW'(ib); dst = AW'(id); load_data = dv;
    va = m[ia]; vb = m[ib]; wr = 1; ar = 0; r = '0;
    case (o)
      4'd0: r = {1'b0, dv};
      4'd1: begin ar = 1; r = x ? ({1'b0, va} + {1'b0, ~vb} + 1) : ({1'b0, va} + {1'b0, vb}); end
      4'd2: begin ar = 1; r = {1'b0, va} + 1; end
      4'd3: begin ar = 1; r = {1'b0, va - 1'b1}; r[W] = (va != 0); end
      4'd4: r = {1'b0, ~va};
      4'd5: begin ar = 1; r = {1'b0, -va}; r[W] = (va == 0); end
      4'd6: r = {1'b0, va | vb};
      4'd7: r = {1'b0, va & vb};
      4'd8: r = {1'b0, va ^ vb};
      4'd9: r = {1'b0, va << 1};
      4'd10: r = {1'b0, va >> 1};
      default: wr = 0;
    endcase
    if ((t1 || t2) && wr) begin
      m[id] = r[W-1:0];
      if (ar) mc = r[W];
    end
    it.regs = flat(); it.c = mc; it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (reg_flat !== it.regs || carry !== it.c) begin
        errors++;
        $display("FAIL %s: regs %h carry %b, expected regs %h carry %b",
                 it.tag, reg_flat, carry, it.regs, it.c);
      end
    end
  end

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m[i] = '0;
    mc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (reg_flat !== '0 || carry !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset: regs %h carry %b, expected 0 0", reg_flat, carry);
    end

    do_op(1, 0, 0, 4'd0, 0, 0, 0, 8'hC9, "R8 load k1");
    do_op(0, 1, 0, 4'd0, 0, 0, 1, 8'h37, "R2 load via k2 alone");
    do_op(0, 0, 0, 4'd0, 0, 0, 2, 8'hFF, "R1 idle load ignored");
    do_op(0, 0, 1, 4'd1, 0, 1, 0, 8'h00, "R1 idle subtract ignored");
    do_op(1, 0, 0, 4'd9, 0, 0, 2, 8'h00, "R7 shl 11001001");
    do_op(1, 0, 0, 4'd10, 0, 0, 3, 8'h00, "R7 shr 11001001");
    do_op(1, 1, 0, 4'd1, 0, 1, 2, 8'h00, "R3 add with carry");
    do_op(1, 0, 1, 4'd1, 1, 0, 3, 8'h00, "R3 subtract borrow");
    do_op(0, 1, 1, 4'd1, 0, 1, 3, 8'h00, "R3 subtract no borrow");
    do_op(1, 0, 0, 4'd0, 0, 0, 2, 8'h00, "R8 load zero");
    do_op(1, 0, 0, 4'd3, 2, 0, 2, 8'h00, "R4 decrement zero");
    do_op(1, 0, 0, 4'd2, 2, 0, 2, 8'h00, "R4 increment wrap");
    do_op(1, 0, 0, 4'd5, 2, 0, 3, 8'h00, "R5 negate zero");
    do_op(1, 0, 0, 4'd4, 0, 0, 1, 8'h00, "R5 not");
    do_op(1, 0, 0, 4'd6, 0, 1, 2, 8'h00, "R6 or");
    do_op(1, 0, 0, 4'd7, 0, 1, 3, 8'h00, "R6 and");
    do_op(1, 0, 0, 4'd8, 0, 0, 0, 8'h00, "R6 xor self");
    do_op(1, 1, 0, 4'd12, 1, 2, 3, 8'hAA, "R9 undefined opcode");
    do_op(1, 0, 0, 4'd1, 1, 1, 1, 8'h00, "R10 add src equals dst");

    for (int n = 0; n < 400; n++) begin
      logic [3:0] o;
      o = 4'($urandom_range(0, 15));
      do_op(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
            o, $urandom_range(0, N-1), $urandom_range(0, N-1), $urandom_range(0, N-1),
            W'($urandom), "R10 random mix");
    end

    @(negedge clk);
    k1 = 0; k2 = 0;
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule